// File: doc/BRIEF.md
# Aging Wait Queue for Suspended Block Requests

This block parks requests that a memory-side merging controller cannot serve yet, because the target block is suspended. It holds at most one entry per process. Each entry keeps the block address, the requester id and a kind flag. A block-fetch entry also records the value of a free-running timestamp counter when it enters. A lock entry takes part in no aging and waits only for its block to be reset.

When the controller reinitializes a block, it pulses a reinit event carrying the address. Every stored entry for that address is then handed back on a release stream, oldest first, so the controller can replay it as a fresh request. A scan runs at a programmable interval. It marks block-fetch entries whose age has passed a programmable threshold. For each marked entry the block offers one broadcast-invalidate command, oldest marked entry first. This breaks a deadlock in which processors hold copies that other processors are waiting for.

The insert, release and invalidate interfaces are valid/ready streams. A transfer takes place on a cycle where both valid and ready are high. Insert ready falls as soon as the queue is full, and it does not count a release that takes place in the same cycle. While the consumer stalls, an offered release keeps its payload unchanged. An offered invalidate keeps its payload unchanged until a transfer takes place, unless its own entry is released first.

Top module: `suspend_queue`

## Requirements
- R1: `ins_ready` is high exactly when fewer than NPROC entries are stored, whatever `rel_ready` does in that cycle. An insert offered while `ins_ready` is low is not stored.
- R2: After reset the queue is empty, `ins_ready` is 1, and `rel_valid` and `inv_valid` are 0.
- R3: A `reinit_valid` pulse marks for release every stored entry whose address equals `reinit_addr`, both fetch entries and lock entries. Entries with other addresses are not marked. An entry inserted in the same cycle as the pulse is not marked.
- R4: Marked entries leave on the release stream in arrival order, one per cycle while `rel_ready` is high. `rel_lock` is 1 for a lock entry. An entry is removed on its transfer.
- R5: The timestamp starts at 0 at reset and increments on every clock edge. Age is (current stamp minus stored stamp) modulo 2^TS_W, so the age stays correct after the counter wraps.
- R6: Counting edges after reset from 0, scan ticks occur on edge number `cfg_interval` and then every `cfg_interval`+1 edges. On a tick, a fetch entry is marked stale if all of the following hold:
  - its age is greater than `cfg_age`;
  - it has not been marked stale before;
  - it is not already marked for release.
- R7: `inv_valid` offers the address of the oldest-arrived stale entry. After its transfer, that entry is never offered for invalidation again.
- R8: Lock entries are never marked stale and never produce an invalidate.
- R9: While `rel_valid` is high and `rel_ready` is low, the release payload is held unchanged. While `inv_valid` is high and `inv_ready` is low, the invalidate payload is held unchanged as long as no release takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | IV_W | Scan period minus one |
| cfg_age | input | TS_W | Age threshold; an entry older than this is stale |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Queue can accept an insert |
| ins_addr | input | ADDR_W | Block address of the waiting request |
| ins_pid | input | PID_W | Requester id |
| ins_lock | input | 1 | 1 = lock request, 0 = block fetch |
| reinit_valid | input | 1 | Block-reinitialize event |
| reinit_addr | input | ADDR_W | Address of the reinitialized block |
| rel_valid | output | 1 | Released entry offered |
| rel_ready | input | 1 | Consumer takes the released entry |
| rel_addr | output | ADDR_W | Released entry address |
| rel_pid | output | PID_W | Released entry requester id |
| rel_lock | output | 1 | Released entry is a lock request |
| inv_valid | output | 1 | Broadcast invalidate offered |
| inv_ready | input | 1 | Invalidate accepted |
| inv_addr | output | ADDR_W | Block to invalidate |

## Verification
The hardest case to reach from the ports is two fetch entries that become stale in the same scan tick while the invalidate consumer is stalled. That case alone shows that the oldest entry wins and that the offer is held. The stimulus produces it with a long scan interval and inserts on back-to-back cycles. Both entries then pass the threshold before the first tick, while `inv_ready` is held low. Wraparound of the age computation is reached by letting the stamp counter roll over before an insert. The threshold-and-interval sweep then predicts the detection edge arithmetically from the edge count since reset.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Per-entry status bits of the wait queue
  typedef struct packed {
    logic vld;       // slot occupied
    logic lock;      // lock request: excluded from aging
    logic rel_pend;  // block was reset, waiting to leave
    logic inv_pend;  // stale, invalidate not yet taken
    logic inv_done;  // invalidate already issued once
  } sq_flags_t;

  localparam sq_flags_t SQ_EMPTY = '0;
endpackage

// File: rtl/sq_clock.sv
module sq_clock #(
  parameter int TS_W = 8,
  parameter int IV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IV_W-1:0] cfg_interval,
  output logic [TS_W-1:0] ts_now,
  output logic            scan_tick
);
  logic [IV_W-1:0] iv_cnt;

  assign scan_tick = (iv_cnt >= cfg_interval);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_now <= '0;
      iv_cnt <= '0;
    end else begin
      ts_now <= ts_now + 1'b1;
      iv_cnt <= scan_tick ? '0 : iv_cnt + 1'b1;
    end
  end

  // R6: with a non-zero interval that stays put, ticks never come back to back
  p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_tick && (cfg_interval != '0) ##1 (cfg_interval == $past(cfg_interval)) |-> !scan_tick);
endmodule

// File: rtl/sq_pick.sv
module sq_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             out_ready,
  input  logic             rm_valid,
  input  logic [IDX_W-1:0] rm_idx,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx
);
  logic [IDX_W-1:0] first_idx;
  logic             hold;
  logic [IDX_W-1:0] hold_idx;

  // lowest index is the oldest arrival
  always_comb begin
    first_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) first_idx = IDX_W'(i);
  end

  assign out_valid = hold | (|req);
  assign out_idx   = hold ? hold_idx : first_idx;

  // keep the offered slot while stalled, following it when a lower slot leaves
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold     <= 1'b0;
      hold_idx <= '0;
    end else if (out_valid && out_ready) begin
      hold <= 1'b0;
    end else if (out_valid) begin
      if (rm_valid && rm_idx == out_idx) begin
        hold <= 1'b0;
      end else begin
        hold     <= 1'b1;
        hold_idx <= (rm_valid && rm_idx < out_idx) ? out_idx - 1'b1 : out_idx;
      end
    end
  end

  // R9: a stalled offer stays on the same slot when nothing leaves the queue
  p_hold_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !rm_valid |=> out_valid && (out_idx == $past(out_idx)));
endmodule

// File: rtl/suspend_queue.sv
module suspend_queue
  import sq_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 6,
  parameter int PID_W  = 2,
  parameter int TS_W   = 8,
  parameter int IV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IV_W-1:0]   cfg_interval,
  input  logic [TS_W-1:0]   cfg_age,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [PID_W-1:0]  ins_pid,
  input  logic              ins_lock,
  input  logic              reinit_valid,
  input  logic [ADDR_W-1:0] reinit_addr,
  output logic              rel_valid,
  input  logic              rel_ready,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [PID_W-1:0]  rel_pid,
  output logic              rel_lock,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [ADDR_W-1:0] inv_addr
);
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam int CNT_W = $clog2(NPROC + 1);

  sq_flags_t         fl_q  [NPROC];
  sq_flags_t         upd   [NPROC];
  sq_flags_t         fl_n  [NPROC];
  logic [ADDR_W-1:0] ad_q  [NPROC];
  logic [ADDR_W-1:0] ad_n  [NPROC];
  logic [PID_W-1:0]  pid_q [NPROC];
  logic [PID_W-1:0]  pid_n [NPROC];
  logic [TS_W-1:0]   ts_q  [NPROC];
  logic [TS_W-1:0]   ts_n  [NPROC];
  logic [CNT_W-1:0]  count_q, count_n, cnt_mid;

  logic [TS_W-1:0]   ts_now;
  logic              scan_tick;
  logic [NPROC-1:0]  rel_req, inv_req;
  logic [IDX_W-1:0]  rel_idx, inv_idx;
  logic              rel_fire, inv_fire, ins_fire;

  sq_clock #(.TS_W(TS_W), .IV_W(IV_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
    .ts_now(ts_now), .scan_tick(scan_tick)
  );

  for (genvar g = 0; g < NPROC; g++) begin : g_req
    assign rel_req[g] = fl_q[g].vld & fl_q[g].rel_pend;
    assign inv_req[g] = fl_q[g].vld & fl_q[g].inv_pend;
  end

  sq_pick #(.N(NPROC), .IDX_W(IDX_W)) u_rel_pick (
    .clk(clk), .rst_n(rst_n), .req(rel_req), .out_ready(rel_ready),
    .rm_valid(1'b0), .rm_idx('0), .out_valid(rel_valid), .out_idx(rel_idx)
  );

  sq_pick #(.N(NPROC), .IDX_W(IDX_W)) u_inv_pick (
    .clk(clk), .rst_n(rst_n), .req(inv_req), .out_ready(inv_ready),
    .rm_valid(rel_fire), .rm_idx(rel_idx), .out_valid(inv_valid), .out_idx(inv_idx)
  );

  assign ins_ready = (count_q < CNT_W'(NPROC));
  assign ins_fire  = ins_valid & ins_ready;
  assign rel_fire  = rel_valid & rel_ready;
  assign inv_fire  = inv_valid & inv_ready;

  assign rel_addr = ad_q[rel_idx];
  assign rel_pid  = pid_q[rel_idx];
  assign rel_lock = fl_q[rel_idx].lock;
  assign inv_addr = ad_q[inv_idx];

  always_comb begin
    // status updates in place
    for (int i = 0; i < NPROC; i++) begin
      upd[i] = fl_q[i];
      if (fl_q[i].vld) begin
        if (reinit_valid && ad_q[i] == reinit_addr)
          upd[i].rel_pend = 1'b1;
        if (scan_tick && !fl_q[i].lock && !fl_q[i].rel_pend && !fl_q[i].inv_pend &&
            !fl_q[i].inv_done && (TS_W'(ts_now - ts_q[i]) > cfg_age))
          upd[i].inv_pend = 1'b1;
        if (inv_fire && inv_idx == IDX_W'(i)) begin
          upd[i].inv_pend = 1'b0;
          upd[i].inv_done = 1'b1;
        end
      end
    end
    // compaction on release keeps slot order equal to arrival order
    for (int i = 0; i < NPROC; i++) begin
      fl_n[i]  = upd[i];
      ad_n[i]  = ad_q[i];
      pid_n[i] = pid_q[i];
      ts_n[i]  = ts_q[i];
    end
    if (rel_fire) begin
      for (int i = 0; i < NPROC - 1; i++) begin
        if (IDX_W'(i) >= rel_idx) begin
          fl_n[i]  = upd[i+1];
          ad_n[i]  = ad_q[i+1];
          pid_n[i] = pid_q[i+1];
          ts_n[i]  = ts_q[i+1];
        end
      end
      fl_n[NPROC-1] = SQ_EMPTY;
    end
    cnt_mid = count_q - CNT_W'(rel_fire);
    // append at the tail
    if (ins_fire) begin
      for (int i = 0; i < NPROC; i++) begin
        if (CNT_W'(i) == cnt_mid) begin
          fl_n[i]      = SQ_EMPTY;
          fl_n[i].vld  = 1'b1;
          fl_n[i].lock = ins_lock;
          ad_n[i]      = ins_addr;
          pid_n[i]     = ins_pid;
          ts_n[i]      = ts_now;
        end
      end
    end
    count_n = cnt_mid + CNT_W'(ins_fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      for (int i = 0; i < NPROC; i++) begin
        fl_q[i]  <= SQ_EMPTY;
        ad_q[i]  <= '0;
        pid_q[i] <= '0;
        ts_q[i]  <= '0;
      end
    end else begin
      count_q <= count_n;
      for (int i = 0; i < NPROC; i++) begin
        fl_q[i]  <= fl_n[i];
        ad_q[i]  <= ad_n[i];
        pid_q[i] <= pid_n[i];
        ts_q[i]  <= ts_n[i];
      end
    end
  end

  // R1: occupancy never exceeds one entry per process
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(NPROC));

  // R1: an accepted insert without a release grows the queue by one
  p_accept_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire && !rel_fire |=> count_q == $past(count_q) + 1'b1);

  // R4: an empty queue offers nothing
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q == '0 |-> !rel_valid && !inv_valid);

  // R9: a stalled release keeps its payload
  p_rel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !rel_ready |=> rel_valid && $stable(rel_addr) && $stable(rel_pid) && $stable(rel_lock));

  for (genvar g = 0; g < NPROC; g++) begin : g_chk
    // R8: lock entries never age
    p_lock_not_aged_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_q[g].vld && fl_q[g].lock |-> !fl_q[g].inv_pend && !fl_q[g].inv_done);
    // R7: an entry already invalidated is never stale again
    p_done_no_reflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_q[g].inv_done |-> !fl_q[g].inv_pend);
  end
endmodule

// File: tb/suspend_queue_bench.sv
`timescale 1ns/1ps
module suspend_queue_bench;
  localparam int NPROC = 4, ADDR_W = 4, PID_W = 2, TS_W = 6, IV_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IV_W-1:0]   cfg_interval = '0;
  logic [TS_W-1:0]   cfg_age = '0;
  logic              ins_valid = 1'b0, ins_lock = 1'b0;
  logic [ADDR_W-1:0] ins_addr = '0, reinit_addr = '0;
  logic [PID_W-1:0]  ins_pid = '0;
  logic              reinit_valid = 1'b0, rel_ready = 1'b0, inv_ready = 1'b0;
  logic              ins_ready, rel_valid, rel_lock, inv_valid;
  logic [ADDR_W-1:0] rel_addr, inv_addr;
  logic [PID_W-1:0]  rel_pid;

  int n_chk = 0, n_bad = 0, ecount = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;

  suspend_queue #(.NPROC(NPROC), .ADDR_W(ADDR_W), .PID_W(PID_W), .TS_W(TS_W), .IV_W(IV_W))
  u_suspend_queue (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_age(cfg_age),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_pid(ins_pid),
    .ins_lock(ins_lock), .reinit_valid(reinit_valid), .reinit_addr(reinit_addr),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_addr(rel_addr), .rel_pid(rel_pid),
    .rel_lock(rel_lock), .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int iv, input int age);
    @(negedge clk);
    rst_n = 1'b0; cfg_interval = IV_W'(iv); cfg_age = TS_W'(age);
    ins_valid = 0; reinit_valid = 0; rel_ready = 0; inv_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input int a, input int p, input bit lk, output int e);
    ins_valid = 1; ins_addr = ADDR_W'(a); ins_pid = PID_W'(p); ins_lock = lk;
    e = ecount;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic reinit(input int a);
    reinit_valid = 1; reinit_addr = ADDR_W'(a);
    @(negedge clk);
    reinit_valid = 0;
  endtask

  task automatic take_rel();
    rel_ready = 1;
    @(negedge clk);
    rel_ready = 0;
  endtask

  task automatic take_inv();
    inv_ready = 1;
    @(negedge clk);
    inv_ready = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0, e1, seen, expd, quiet;

    // R2: reset state
    do_reset(0, 0);
    chk("R2 ins_ready", int'(ins_ready), 1);
    chk("R2 rel_valid", int'(rel_valid), 0);
    chk("R2 inv_valid", int'(inv_valid), 0);

    // R5 R6 R7: sweep threshold and interval; detection edge predicted arithmetically
    for (int thr = 0; thr < 5; thr++) begin
      for (int k = 0; k < 3; k++) begin
        int iv;
        iv = (k == 0) ? 0 : k + 1;
        do_reset(iv, thr);
        repeat ((thr == 2) ? 70 : thr) @(negedge clk);  // 70 forces a stamp wrap (R5)
        push(thr + 1, k, 1'b0, e0);
        seen = -1;
        for (int w = 0; w < 100; w++) begin
          if (inv_valid) begin seen = ecount - 1; break; end
          @(negedge clk);
        end
        expd = e0 + thr + 1;
        while ((expd % (iv + 1)) != iv) expd++;
        chk($sformatf("R6 detect edge thr=%0d iv=%0d", thr, iv), seen, expd);
        chk("R7 inv_addr", int'(inv_addr), thr + 1);
        take_inv();
        quiet = 0;
        for (int w = 0; w < 40; w++) begin
          if (inv_valid) quiet++;
          @(negedge clk);
        end
        chk("R7 no repeat invalidate", quiet, 0);
      end
    end

    // R7 R9: two entries go stale in the same tick, consumer stalled
    do_reset(7, 3);
    push(9, 0, 1'b0, e0);
    push(4, 1, 1'b0, e1);
    for (int w = 0; w < 20; w++) begin
      if (inv_valid) break;
      @(negedge clk);
    end
    chk("R7 oldest first", int'(inv_addr), 9);
    repeat (2) @(negedge clk);
    chk("R9 inv held valid", int'(inv_valid), 1);
    chk("R9 inv held addr", int'(inv_addr), 9);
    take_inv();
    chk("R7 second valid", int'(inv_valid), 1);
    chk("R7 second addr", int'(inv_addr), 4);
    take_inv();
    chk("R7 drained", int'(inv_valid), 0);
    reinit(4);
    chk("R3 release match", int'(rel_valid), 1);
    chk("R3 release addr", int'(rel_addr), 4);
    chk("R3 release pid", int'(rel_pid), 1);
    take_rel();
    chk("R4 removed", int'(rel_valid), 0);

    // R8: lock entry never ages, leaves on its reinit
    do_reset(0, 1);
    push(5, 2, 1'b1, e0);
    quiet = 0;
    for (int w = 0; w < 20; w++) begin
      if (inv_valid) quiet++;
      @(negedge clk);
    end
    chk("R8 lock not aged", quiet, 0);
    reinit(5);
    chk("R8 lock released", int'(rel_valid), 1);
    chk("R4 rel_lock flag", int'(rel_lock), 1);
    take_rel();

    // R1 R3 R4 R9: ordering, full queue, non-matching reinit
    do_reset(15, 63);
    push(3, 0, 1'b0, e0);
    push(7, 1, 1'b0, e0);
    push(3, 2, 1'b0, e0);
    push(3, 3, 1'b1, e0);
    chk("R1 full ready low", int'(ins_ready), 0);
    push(12, 0, 1'b0, e0);  // refused
    reinit(9);
    @(negedge clk);
    chk("R3 no match no release", int'(rel_valid), 0);
    reinit(3);
    chk("R4 first pid", int'(rel_pid), 0);
    repeat (2) @(negedge clk);
    chk("R9 rel held pid", int'(rel_pid), 0);
    rel_ready = 1;
    chk("R4 seq0 pid", int'(rel_pid), 0);
    @(negedge clk);
    chk("R4 seq1 valid", int'(rel_valid), 1);
    chk("R4 seq1 pid", int'(rel_pid), 2);
    @(negedge clk);
    chk("R4 seq2 pid", int'(rel_pid), 3);
    chk("R4 seq2 lock", int'(rel_lock), 1);
    @(negedge clk);
    rel_ready = 0;
    chk("R4 seq done", int'(rel_valid), 0);
    chk("R1 ready again", int'(ins_ready), 1);
    reinit(12);
    chk("R1 refused not stored", int'(rel_valid), 0);
    reinit(7);
    chk("R3 remaining pid", int'(rel_pid), 1);
    take_rel();

    // R3: entry inserted with a same-cycle reinit is not marked
    do_reset(15, 63);
    reinit_valid = 1; reinit_addr = 6;
    push(6, 2, 1'b0, e0);
    reinit_valid = 0;
    @(negedge clk);
    chk("R3 same-cycle insert kept", int'(rel_valid), 0);
    reinit(6);
    chk("R3 later reinit releases", int'(rel_valid), 1);
    take_rel();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule